// File: doc/BRIEF.md
# CAN Operating-Mode and Bus-Off Recovery Controller

This block keeps track of the operating mode of a CAN controller: initialization, normal, sleep and bus-off. The fault-confinement logic supplies the transmit error counter. The bit-timing logic supplies the sampled receive line and a one-cycle strobe for each bit. Software gives single-cycle request strobes. Two configuration bits choose whether leaving bus-off and leaving sleep happen on their own or wait for software.

In bus-off the block counts recovery runs. A run is a group of consecutive recessive bits. When enough runs are complete, a recovery-complete flag rises. The controller then goes back to normal mode, either at once or on a software recovery request, depending on configuration. In sleep, a recessive-to-dominant transition on the sampled line counts as bus activity. It raises a one-cycle wakeup pulse and can also wake the controller.

All pins are plain control and status levels or strobes. No data stream crosses the block's edge, so no valid/ready handshake and no back-pressure apply.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset, mode is INIT (code 0), and bus_off, recov_done and wake_evt are all low.
- R2: Mode codes are 0 INIT, 1 NORMAL, 2 SLEEP and 3 BUSOFF. Every output changes on the clock edge that samples its cause, so it is visible one cycle after the input. In INIT, req_init_clr moves to NORMAL. Otherwise, req_sleep_set moves to SLEEP.
- R3: In NORMAL, a tec value above TEC_LIMIT (default 255) moves to BUSOFF, and bus_off is high exactly while mode is BUSOFF. A tec value equal to TEC_LIMIT has no effect. Entering bus-off wins over a sleep request in the same cycle.
- R4: In BUSOFF, each strobed recessive bit (rx_bit=1) extends the current run. RUN_LEN consecutive recessive bits complete one run. A strobed dominant bit (rx_bit=0) sets the current run back to zero and keeps the number of completed runs. recov_done rises one cycle after the strobe that completes run number RUN_COUNT.
- R5: With auto_busoff=1, mode becomes NORMAL one cycle after recov_done goes high.
- R6: With auto_busoff=0, req_recover is ignored while recov_done is low. Once recov_done is high, req_recover moves to NORMAL one cycle later.
- R7: The recovery counters are cleared whenever mode is not BUSOFF. recov_done goes low one cycle after mode leaves BUSOFF.
- R8: SLEEP is entered only through req_sleep_set, from INIT or NORMAL.
- R9: Bus activity is a strobed dominant bit whose previous strobed bit was recessive. Activity while in SLEEP pulses wake_evt for one cycle. With auto_wake=1 the same activity also moves to NORMAL.
- R10: With auto_wake=0 the controller stays in SLEEP through bus activity and leaves only on req_sleep_clr, which moves it to NORMAL.
- R11: req_init_set takes priority over every other transition. From any mode it moves to INIT, and it clears both recovery counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tec | input | TEC_W | Transmit error counter value |
| rx_bit | input | 1 | Sampled receive bit, 1 = recessive |
| bit_stb | input | 1 | One-cycle strobe marking a valid rx_bit |
| req_init_set | input | 1 | Request to enter initialization |
| req_init_clr | input | 1 | Request to leave initialization |
| req_sleep_set | input | 1 | Request to enter sleep |
| req_sleep_clr | input | 1 | Request to leave sleep |
| req_recover | input | 1 | Software bus-off recovery request |
| auto_busoff | input | 1 | Leave bus-off automatically when recovery is complete |
| auto_wake | input | 1 | Leave sleep automatically on bus activity |
| mode | output | 2 | Current mode code |
| bus_off | output | 1 | High while in bus-off |
| recov_done | output | 1 | Recovery sequence complete |
| wake_evt | output | 1 | One-cycle pulse on bus activity in sleep |

## Verification
The bench builds the block with RUN_LEN=4 and RUN_COUNT=3, and keeps TEC_W=9 and TEC_LIMIT=255. The short recovery sequence brings several things within reach: a dominant bit breaking a run, a recovery request arriving too early, the last strobe of the final run, and clearing by an initialization request part-way through. Each of these shows up in a handful of strobes. The real 255/256 threshold on tec is checked directly.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef enum logic [1:0] {
    MODE_INIT   = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_SLEEP  = 2'd2,
    MODE_BUSOFF = 2'd3
  } mode_t;
endpackage

// File: rtl/can_recov_counter.sv
// Counts runs of consecutive recessive bits while bus-off is active.
module can_recov_counter #(
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic clear,
  input  logic bit_stb,
  input  logic rx_bit,
  output logic done
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam int CNT_W = $clog2(RUN_COUNT + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(RUN_COUNT);

  logic [RUN_W-1:0] run_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      cnt_q <= '0;
    end else if (clear || !enable) begin
      run_q <= '0;
      cnt_q <= '0;
    end else if (bit_stb && (cnt_q != CNT_FULL)) begin
      if (!rx_bit) begin
        run_q <= '0;
      end else if (run_q == RUN_LAST) begin
        run_q <= '0;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign done = (cnt_q == CNT_FULL);
endmodule

// File: rtl/can_wake_detect.sv
// Detects recessive-to-dominant edges on the strobed receive line.
module can_wake_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic rx_bit,
  input  logic in_sleep,
  output logic activity,
  output logic wake_evt
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
    end else if (bit_stb) begin
      prev_q <= rx_bit;
    end
  end

  assign activity = bit_stb && prev_q && !rx_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_evt <= 1'b0;
    end else begin
      wake_evt <= activity && in_sleep;
    end
  end
endmodule

// File: rtl/can_mode_fsm.sv
// Mode state machine with init-request priority.
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tec_over,
  input  logic  activity,
  input  logic  recov_done,
  input  logic  req_init_set,
  input  logic  req_init_clr,
  input  logic  req_sleep_set,
  input  logic  req_sleep_clr,
  input  logic  req_recover,
  input  logic  auto_busoff,
  input  logic  auto_wake,
  output mode_t mode
);
  mode_t mode_d;

  always_comb begin
    mode_d = mode;
    if (req_init_set) begin
      mode_d = MODE_INIT;
    end else begin
      unique case (mode)
        MODE_INIT: begin
          if (req_init_clr)       mode_d = MODE_NORMAL;
          else if (req_sleep_set) mode_d = MODE_SLEEP;
        end
        MODE_NORMAL: begin
          if (tec_over)           mode_d = MODE_BUSOFF;
          else if (req_sleep_set) mode_d = MODE_SLEEP;
        end
        MODE_SLEEP: begin
          if (activity && auto_wake) mode_d = MODE_NORMAL;
          else if (req_sleep_clr)    mode_d = MODE_NORMAL;
        end
        MODE_BUSOFF: begin
          if (recov_done && (auto_busoff || req_recover)) mode_d = MODE_NORMAL;
        end
        default: mode_d = MODE_INIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= MODE_INIT;
    else        mode <= mode_d;
  end
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int TEC_W     = 9,
  parameter int TEC_LIMIT = 255,
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TEC_W-1:0] tec,
  input  logic             rx_bit,
  input  logic             bit_stb,
  input  logic             req_init_set,
  input  logic             req_init_clr,
  input  logic             req_sleep_set,
  input  logic             req_sleep_clr,
  input  logic             req_recover,
  input  logic             auto_busoff,
  input  logic             auto_wake,
  output logic [1:0]       mode,
  output logic             bus_off,
  output logic             recov_done,
  output logic             wake_evt
);
  localparam logic [TEC_W-1:0] TEC_THR = TEC_W'(TEC_LIMIT);

  mode_t mode_q;
  logic  tec_over;
  logic  activity;

  assign tec_over = (tec > TEC_THR);

  can_mode_fsm fsm_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tec_over     (tec_over),
    .activity     (activity),
    .recov_done   (recov_done),
    .req_init_set (req_init_set),
    .req_init_clr (req_init_clr),
    .req_sleep_set(req_sleep_set),
    .req_sleep_clr(req_sleep_clr),
    .req_recover  (req_recover),
    .auto_busoff  (auto_busoff),
    .auto_wake    (auto_wake),
    .mode         (mode_q)
  );

  can_recov_counter #(
    .RUN_LEN  (RUN_LEN),
    .RUN_COUNT(RUN_COUNT)
  ) recov_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (mode_q == MODE_BUSOFF),
    .clear  (req_init_set),
    .bit_stb(bit_stb),
    .rx_bit (rx_bit),
    .done   (recov_done)
  );

  can_wake_detect wake_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_stb (bit_stb),
    .rx_bit  (rx_bit),
    .in_sleep(mode_q == MODE_SLEEP),
    .activity(activity),
    .wake_evt(wake_evt)
  );

  assign mode    = mode_q;
  assign bus_off = (mode_q == MODE_BUSOFF);
endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk #(
  parameter int TEC_W     = 9,
  parameter int TEC_LIMIT = 255
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TEC_W-1:0] tec,
  input logic             req_init_set,
  input logic             req_sleep_set,
  input logic             auto_busoff,
  input logic [1:0]       mode,
  input logic             bus_off,
  input logic             recov_done,
  input logic             wake_evt
);
  localparam logic [TEC_W-1:0] THR = TEC_W'(TEC_LIMIT);

  // R3
  busoff_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && tec > THR && !req_init_set) |=> (mode == 2'd3 && bus_off));

  // R6
  no_early_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !recov_done) |=> (mode != 2'd1));

  // R5
  auto_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && recov_done && auto_busoff && !req_init_set) |=> (mode == 2'd1));

  // R11
  init_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_init_set |=> (mode == 2'd0));

  // R8
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd2 && !req_sleep_set) |=> (mode != 2'd2));

  // R9
  wake_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> ($past(mode) == 2'd2));

  // R7
  recov_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd3 && $past(mode) != 2'd3) |-> !recov_done);
endmodule

bind can_mode_ctrl can_mode_ctrl_chk #(
  .TEC_W    (TEC_W),
  .TEC_LIMIT(TEC_LIMIT)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .tec          (tec),
  .req_init_set (req_init_set),
  .req_sleep_set(req_sleep_set),
  .auto_busoff  (auto_busoff),
  .mode         (mode),
  .bus_off      (bus_off),
  .recov_done   (recov_done),
  .wake_evt     (wake_evt)
);

// File: tb/can_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module can_mode_ctrl_tb_top;
  localparam int TEC_W = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TEC_W-1:0] tec = '0;
  logic rx_bit = 1'b1, bit_stb = 1'b0;
  logic iset = 1'b0, iclr = 1'b0, sset = 1'b0, sclr = 1'b0, rec = 1'b0;
  logic abo = 1'b0, awk = 1'b0;
  logic [1:0] mode;
  logic bus_off, recov_done, wake_evt;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  can_mode_ctrl #(
    .TEC_W(TEC_W), .TEC_LIMIT(255), .RUN_LEN(4), .RUN_COUNT(3)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tec(tec), .rx_bit(rx_bit), .bit_stb(bit_stb),
    .req_init_set(iset), .req_init_clr(iclr), .req_sleep_set(sset),
    .req_sleep_clr(sclr), .req_recover(rec), .auto_busoff(abo),
    .auto_wake(awk), .mode(mode), .bus_off(bus_off),
    .recov_done(recov_done), .wake_evt(wake_evt)
  );

  typedef struct packed {
    logic [8:0] tec;
    logic rx, stb, iset, iclr, sset, sclr, rec, abo, awk;
    logic [1:0] emode;
    logic ebo, erd, ewk;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{9'd0,  1,0, 0,1,0,0,0, 0,0, 2'd1,0,0,0, 4'd2},  // R2 leave init
    '{9'd255,1,0, 0,0,0,0,0, 0,0, 2'd1,0,0,0, 4'd3},  // R3 boundary
    '{9'd256,1,0, 0,0,1,0,0, 0,0, 2'd3,1,0,0, 4'd3},  // R3 beats sleep
    '{9'd0,  1,1, 0,0,0,0,0, 0,0, 2'd3,1,0,0, 4'd4},  // R4 run bit 1
    '{9'd0,  1,1, 0,0,0,0,0, 0,0, 2'd3,1,0,0, 4'd4},
    '{9'd0,  0,1, 0,0,0,0,0, 0,0, 2'd3,1,0,0, 4'd4},  // R4 dominant break
    '{9'd0,  1,1, 0,0,0,0,0, 0,0, 2'd3,1,0,0, 4'd4},
    '{9'd0,  1,1, 0,0,0,0,0, 0,0, 2'd3,1,0,0, 4'd4},
    '{9'd0,  1,1, 0,0,0,0,0, 0,0, 2'd3,1,0,0, 4'd4},
    '{9'd0,  1,1, 0,0,0,0,0, 0,0, 2'd3,1,0,0, 4'd4},  // run 1 done
    '{9'd0,  1,0, 0,0,0,0,1, 0,0, 2'd3,1,0,0, 4'd6},  // R6 early request
    '{9'd0,  1,1, 0,0,0,0,0, 0,0, 2'd3,1,0,0, 4'd4},
    '{9'd0,  1,1, 0,0,0,0,0, 0,0, 2'd3,1,0,0, 4'd4},
    '{9'd0,  1,1, 0,0,0,0,0, 0,0, 2'd3,1,0,0, 4'd4},
    '{9'd0,  1,1, 0,0,0,0,0, 0,0, 2'd3,1,0,0, 4'd4},  // run 2 done
    '{9'd0,  1,1, 0,0,0,0,0, 0,0, 2'd3,1,0,0, 4'd4},
    '{9'd0,  0,1, 0,0,0,0,0, 0,0, 2'd3,1,0,0, 4'd4},  // R4 runs kept
    '{9'd0,  1,1, 0,0,0,0,0, 0,0, 2'd3,1,0,0, 4'd4},
    '{9'd0,  1,1, 0,0,0,0,0, 0,0, 2'd3,1,0,0, 4'd4},
    '{9'd0,  1,1, 0,0,0,0,0, 0,0, 2'd3,1,0,0, 4'd4},
    '{9'd0,  1,1, 0,0,0,0,0, 0,0, 2'd3,1,1,0, 4'd4},  // run 3 done
    '{9'd0,  1,0, 0,0,0,0,0, 0,0, 2'd3,1,1,0, 4'd6},  // R6 waits
    '{9'd0,  1,0, 0,0,0,0,1, 0,0, 2'd1,0,1,0, 4'd6},  // R6 exit
    '{9'd0,  1,0, 0,0,0,0,0, 0,0, 2'd1,0,0,0, 4'd7},  // R7 cleared
    '{9'd0,  1,0, 0,0,1,0,0, 0,0, 2'd2,0,0,0, 4'd8},  // R8 sleep
    '{9'd0,  1,1, 0,0,0,0,0, 0,0, 2'd2,0,0,0, 4'd9},
    '{9'd0,  0,1, 0,0,0,0,0, 0,0, 2'd2,0,0,1, 4'd9},  // R9 pulse
    '{9'd0,  1,0, 0,0,0,0,0, 0,0, 2'd2,0,0,0, 4'd10}, // R10 stays
    '{9'd0,  1,1, 0,0,0,0,0, 0,0, 2'd2,0,0,0, 4'd10},
    '{9'd0,  1,0, 0,0,0,1,0, 0,0, 2'd1,0,0,0, 4'd10}, // R10 sw exit
    '{9'd0,  1,0, 0,0,1,0,0, 0,1, 2'd2,0,0,0, 4'd8},
    '{9'd0,  0,1, 0,0,0,0,0, 0,1, 2'd1,0,0,1, 4'd9},  // R9 auto wake
    '{9'd0,  1,0, 0,0,0,0,0, 0,1, 2'd1,0,0,0, 4'd9}
  };

  task automatic check(input logic [1:0] em, input logic ebo, erd, ewk,
                       input int req);
    n_checks++;
    if (mode !== em || bus_off !== ebo || recov_done !== erd || wake_evt !== ewk) begin
      n_errors++;
      $display("FAIL R%0d: mode=%0d bo=%0b rd=%0b wk=%0b expected mode=%0d bo=%0b rd=%0b wk=%0b",
               req, mode, bus_off, recov_done, wake_evt, em, ebo, erd, ewk);
    end
  endtask

  task automatic idle();
    tec = '0; rx_bit = 1'b1; bit_stb = 1'b0;
    iset = 1'b0; iclr = 1'b0; sset = 1'b0; sclr = 1'b0; rec = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      rx_bit = 1'b1; bit_stb = 1'b1;
      @(negedge clk);
    end
    bit_stb = 1'b0;
  endtask

  initial begin
    #200000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(2'd0, 0, 0, 0, 1);  // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check(2'd0, 0, 0, 0, 1);  // R1 after release

    for (int v = 0; v < NV; v++) begin
      tec = VECS[v].tec; rx_bit = VECS[v].rx; bit_stb = VECS[v].stb;
      iset = VECS[v].iset; iclr = VECS[v].iclr; sset = VECS[v].sset;
      sclr = VECS[v].sclr; rec = VECS[v].rec; abo = VECS[v].abo; awk = VECS[v].awk;
      @(negedge clk);
      check(VECS[v].emode, VECS[v].ebo, VECS[v].erd, VECS[v].ewk, int'(VECS[v].req));
    end
    idle();
    awk = 1'b0;

    // R5 automatic bus-off exit
    abo = 1'b1;
    tec = 9'd300;
    tick();
    check(2'd3, 1, 0, 0, 3);
    strobes(11);
    check(2'd3, 1, 0, 0, 4);
    strobes(1);
    check(2'd3, 1, 1, 0, 5);
    tick();
    check(2'd1, 0, 1, 0, 5);
    tick();
    check(2'd1, 0, 0, 0, 7);

    // R11 init request clears counters and wins over other requests
    tec = 9'd256;
    tick();
    strobes(8);
    check(2'd3, 1, 0, 0, 4);
    iset = 1'b1; sset = 1'b1; rec = 1'b1; tec = 9'd400;
    tick();
    check(2'd0, 0, 0, 0, 11);
    iclr = 1'b1;
    tick();
    check(2'd1, 0, 0, 0, 2);
    tec = 9'd256;
    tick();
    strobes(4);
    check(2'd3, 1, 0, 0, 11);  // earlier runs were discarded

    // R11 from bus-off and from sleep, R2 sleep from init
    iset = 1'b1;
    tick();
    check(2'd0, 0, 0, 0, 11);
    sset = 1'b1;
    tick();
    check(2'd2, 0, 0, 0, 2);
    iset = 1'b1; sclr = 1'b1;
    tick();
    check(2'd0, 0, 0, 0, 11);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule